// File: doc/BRIEF.md
# Register Taint Tag Propagation Unit

This block keeps a one-bit taint token beside every general-purpose register of a multi-issue core. Each cycle it takes the decoded fields of up to `LANES` instructions. For each one it receives an operation kind, two source register indices, a destination index and a write enable. It also receives the memory bitmap tag of a load, the fault flag of a speculative load, a per-access flag that relaxes the address check, the raw compare outcome from the datapath and a recovery address. From these it writes the new destination tags. In the same cycle it reports the token of a stored register, the predicate results of compares, recovery redirects for tag checks, and faults when a tainted value is used where that is forbidden.

Tokens combine by OR. An XOR or SUB of a register with itself yields a clean result. A speculative load that faults sets the token and requests zero data instead of trapping. Dedicated set-tag and clear-tag operations write a token directly. A standard compare refuses tainted operands by dropping both predicates. A taint-aware compare ignores the tokens. All lanes read the token file as it stood at the start of the cycle. When lanes collide on a destination, the later lane wins. The datapath arithmetic, the cache and the bitmap in memory sit outside this block.

Top module: `taint_tag_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, every token reads 0 on `tag_vec`.
- R2: Kind 1 (compute) writes `tag[src_a] | tag[src_b]` into the destination token.
- R3: Kind 2 (XOR/SUB) writes 0 when `src_a == src_b`, whatever that register's token is. Otherwise it writes the OR of the two source tokens.
- R4: Kind 3 (load) writes `mem_tag | (cfg_load_addr_or & tag[src_a])`, where `src_a` is the address register.
- R5: Kind 3 (load) and kind 5 (store) raise `consume_fault` when `tag[src_a]` is 1 and `relax_addr` is 0, and a faulting load writes no token. A store drives `store_tag` with `tag[src_b]` and writes no token.
- R6: Kind 4 (speculative load) never raises `consume_fault`. It writes `spec_fault | mem_tag | (tag[src_a] & (!relax_addr | cfg_load_addr_or))` and drives `load_zero` equal to `spec_fault`.
- R7: Kind 6 (tag check) raises `redirect_vld` exactly when `tag[src_a]` is 1, and `redirect_pc` carries that lane's `rec_target`.
- R8: Kind 7 (standard compare) drives `pred_t = cmp_raw` and `pred_f = !cmp_raw` when both source tokens are 0, and drives both predicates to 0 otherwise. Kind 8 (taint-aware compare) always drives `cmp_raw` and `!cmp_raw`. Other kinds drive both predicates to 0.
- R9: Kind 11 (move to a special-purpose or branch-target register) raises `sec_viol` exactly when `tag[src_a]` is 1.
- R10: Kind 9 (set tag) writes 1 and kind 10 (clear tag) writes 0 to the destination token. No kind writes a token while `wr_en` is 0.
- R11: Register 0 always reads as clean, both on `tag_vec[0]` and as a source, and writes aimed at it are dropped.
- R12: When several lanes write one token in the same cycle, the highest-numbered lane's value is kept.
- R13: All lanes see the tokens as they stood at the start of the cycle. A cycle with no valid lane leaves every token unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load_addr_or | input | 1 | Also OR the address token into load results |
| op_valid | input | LANES | Lane carries an instruction |
| op_kind | input | 4*LANES | Operation kind per lane (0 = none) |
| wr_en | input | LANES | Destination token write enable |
| src_a | input | AW*LANES | First source / address register index |
| src_b | input | AW*LANES | Second source / store data register index |
| dst | input | AW*LANES | Destination register index |
| mem_tag | input | LANES | Bitmap tag of the loaded location |
| spec_fault | input | LANES | Speculative load hit a fault |
| relax_addr | input | LANES | Skip the tainted-address check for this access |
| cmp_raw | input | LANES | Untagged compare outcome from the datapath |
| rec_target | input | TW*LANES | Recovery address for tag checks |
| store_tag | output | LANES | Token of the stored data register |
| load_zero | output | LANES | Force zero data for a faulted speculative load |
| pred_t | output | LANES | True predicate |
| pred_f | output | LANES | False predicate |
| redirect_vld | output | LANES | Tag check found a taint |
| redirect_pc | output | TW*LANES | Recovery address |
| consume_fault | output | LANES | Tainted address used by a load or store |
| sec_viol | output | LANES | Tainted value moved to a protected register |
| tag_vec | output | NREG | Current token of every register |

## Verification
Every operation kind is swept over all combinations of its source tokens and its side inputs: memory tag, speculative fault, relax flag, configuration bit and raw compare outcome. Each sweep separates OR merging from pass-through of a single source, and separates self-cancelling XOR/SUB from the distinct-register case. The sweeps also tell the standard compare from the taint-aware one. Before each destination write, the destination token is preset to the opposite of its expected value, so a dropped or spurious write shows up. Dual-lane patterns aim both lanes at one register in both orders, and make one lane read a token that the other lane writes, which tells lane priority apart from intra-cycle forwarding.

// File: rtl/taint_pkg.sv
package taint_pkg;
   typedef enum logic [3:0] {
      K_NOP    = 4'd0,
      K_ALU    = 4'd1,
      K_XSELF  = 4'd2,
      K_LOAD   = 4'd3,
      K_SPECLD = 4'd4,
      K_STORE  = 4'd5,
      K_CHECK  = 4'd6,
      K_CMP    = 4'd7,
      K_CMPT   = 4'd8,
      K_SETT   = 4'd9,
      K_CLRT   = 4'd10,
      K_MOVSP  = 4'd11
   } op_kind_e;
   localparam int KIND_W = 4;
endpackage

// File: rtl/taint_lane_eval.sv
module taint_lane_eval
   import taint_pkg::*;
#(
   parameter int TW = 16
) (
   input  logic                valid,
   input  logic [KIND_W-1:0]   kind,
   input  logic                wr_en,
   input  logic                tag_a,
   input  logic                tag_b,
   input  logic                same_src,
   input  logic                mem_tag,
   input  logic                spec_fault,
   input  logic                relax,
   input  logic                cmp_raw,
   input  logic                cfg_addr_or,
   input  logic [TW-1:0]       rec_pc,
   output logic                wr,
   output logic                wr_val,
   output logic                store_tag,
   output logic                load_zero,
   output logic                pred_t,
   output logic                pred_f,
   output logic                redirect,
   output logic [TW-1:0]       redirect_pc,
   output logic                consume_fault,
   output logic                sec_viol
);
   logic addr_bad;
   assign addr_bad    = tag_a & ~relax;
   assign redirect_pc = rec_pc;

   always_comb begin
      wr            = 1'b0;
      wr_val        = 1'b0;
      store_tag     = 1'b0;
      load_zero     = 1'b0;
      pred_t        = 1'b0;
      pred_f        = 1'b0;
      redirect      = 1'b0;
      consume_fault = 1'b0;
      sec_viol      = 1'b0;
      if (valid) begin
         case (op_kind_e'(kind))
            K_ALU: begin
               wr     = wr_en;
               wr_val = tag_a | tag_b;
            end
            K_XSELF: begin
               wr     = wr_en;
               wr_val = same_src ? 1'b0 : (tag_a | tag_b);
            end
            K_LOAD: begin
               consume_fault = addr_bad;
               wr            = wr_en & ~addr_bad;
               wr_val        = mem_tag | (cfg_addr_or & tag_a);
            end
            K_SPECLD: begin
               wr        = wr_en;
               load_zero = spec_fault;
               wr_val    = spec_fault | mem_tag | (tag_a & (~relax | cfg_addr_or));
            end
            K_STORE: begin
               consume_fault = addr_bad;
               store_tag     = tag_b;
            end
            K_CHECK: redirect = tag_a;
            K_CMP: begin
               pred_t = ~(tag_a | tag_b) & cmp_raw;
               pred_f = ~(tag_a | tag_b) & ~cmp_raw;
            end
            K_CMPT: begin
               pred_t = cmp_raw;
               pred_f = ~cmp_raw;
            end
            K_SETT: begin
               wr     = wr_en;
               wr_val = 1'b1;
            end
            K_CLRT: begin
               wr     = wr_en;
               wr_val = 1'b0;
            end
            K_MOVSP: sec_viol = tag_a;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/taint_tag_file.sv
module taint_tag_file #(
   parameter int NREG  = 16,
   parameter int LANES = 2,
   parameter int NRD   = 2 * LANES,
   localparam int AW   = $clog2(NREG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LANES-1:0]     wr,
   input  logic [LANES*AW-1:0]  wr_idx,
   input  logic [LANES-1:0]     wr_val,
   input  logic [NRD*AW-1:0]    rd_idx,
   output logic [NRD-1:0]       rd_tag,
   output logic [NREG-1:0]      tag_vec
);
   logic [NREG-1:0] tag_q, tag_d;

   always_comb begin
      tag_d = tag_q;
      for (int l = 0; l < LANES; l++) begin
         if (wr[l] && wr_idx[l*AW +: AW] != '0)
            tag_d[wr_idx[l*AW +: AW]] = wr_val[l];
      end
      tag_d[0] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tag_q <= '0;
      else        tag_q <= tag_d;
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_tag[p] = tag_q[rd_idx[p*AW +: AW]];
   end

   assign tag_vec = tag_q;
endmodule

// File: rtl/taint_tag_unit.sv
module taint_tag_unit
   import taint_pkg::*;
#(
   parameter int NREG  = 16,
   parameter int LANES = 2,
   parameter int TW    = 16,
   localparam int AW   = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_load_addr_or,
   input  logic [LANES-1:0]       op_valid,
   input  logic [KIND_W*LANES-1:0] op_kind,
   input  logic [LANES-1:0]       wr_en,
   input  logic [AW*LANES-1:0]    src_a,
   input  logic [AW*LANES-1:0]    src_b,
   input  logic [AW*LANES-1:0]    dst,
   input  logic [LANES-1:0]       mem_tag,
   input  logic [LANES-1:0]       spec_fault,
   input  logic [LANES-1:0]       relax_addr,
   input  logic [LANES-1:0]       cmp_raw,
   input  logic [TW*LANES-1:0]    rec_target,
   output logic [LANES-1:0]       store_tag,
   output logic [LANES-1:0]       load_zero,
   output logic [LANES-1:0]       pred_t,
   output logic [LANES-1:0]       pred_f,
   output logic [LANES-1:0]       redirect_vld,
   output logic [TW*LANES-1:0]    redirect_pc,
   output logic [LANES-1:0]       consume_fault,
   output logic [LANES-1:0]       sec_viol,
   output logic [NREG-1:0]        tag_vec
);
   localparam int NRD = 2 * LANES;

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (TW < 1) begin : g_bad_tw
      $error("TW must be at least 1");
   end

   logic [LANES-1:0]    wr, wr_val;
   logic [NRD*AW-1:0]   rd_idx;
   logic [NRD-1:0]      rd_tag;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign rd_idx[(2*l)*AW +: AW]   = src_a[l*AW +: AW];
      assign rd_idx[(2*l+1)*AW +: AW] = src_b[l*AW +: AW];

      taint_lane_eval #(.TW(TW)) eval_i (
         .valid         (op_valid[l]),
         .kind          (op_kind[l*KIND_W +: KIND_W]),
         .wr_en         (wr_en[l]),
         .tag_a         (rd_tag[2*l]),
         .tag_b         (rd_tag[2*l+1]),
         .same_src      (src_a[l*AW +: AW] == src_b[l*AW +: AW]),
         .mem_tag       (mem_tag[l]),
         .spec_fault    (spec_fault[l]),
         .relax         (relax_addr[l]),
         .cmp_raw       (cmp_raw[l]),
         .cfg_addr_or   (cfg_load_addr_or),
         .rec_pc        (rec_target[l*TW +: TW]),
         .wr            (wr[l]),
         .wr_val        (wr_val[l]),
         .store_tag     (store_tag[l]),
         .load_zero     (load_zero[l]),
         .pred_t        (pred_t[l]),
         .pred_f        (pred_f[l]),
         .redirect      (redirect_vld[l]),
         .redirect_pc   (redirect_pc[l*TW +: TW]),
         .consume_fault (consume_fault[l]),
         .sec_viol      (sec_viol[l])
      );
   end

   taint_tag_file #(.NREG(NREG), .LANES(LANES), .NRD(NRD)) file_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr),
      .wr_idx  (dst),
      .wr_val  (wr_val),
      .rd_idx  (rd_idx),
      .rd_tag  (rd_tag),
      .tag_vec (tag_vec)
   );
endmodule

// File: rtl/taint_tag_unit_chk.sv
module taint_tag_unit_chk #(
   parameter int NREG  = 16,
   parameter int LANES = 2,
   localparam int AW   = $clog2(NREG)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [LANES-1:0]       op_valid,
   input logic [4*LANES-1:0]     op_kind,
   input logic [LANES-1:0]       wr_en,
   input logic [AW*LANES-1:0]    dst,
   input logic [LANES-1:0]       pred_t,
   input logic [LANES-1:0]       pred_f,
   input logic [LANES-1:0]       redirect_vld,
   input logic [LANES-1:0]       load_zero,
   input logic [LANES-1:0]       consume_fault,
   input logic [NREG-1:0]        tag_vec
);
   localparam int LL = LANES - 1;

   // R1
   reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> tag_vec == '0);

   // R11
   zero_reg_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_vec[0] == 1'b0);

   // R13
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid == '0 |=> $stable(tag_vec));

   // R10
   set_last_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid[LL] && op_kind[4*LL +: 4] == 4'd9 && wr_en[LL] && dst[AW*LL +: AW] != '0)
      |=> tag_vec[$past(dst[AW*LL +: AW])]);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      // R8
      pred_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(pred_t[l] && pred_f[l]));
      // R7
      redirect_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
         redirect_vld[l] |-> (op_valid[l] && op_kind[4*l +: 4] == 4'd6));
      // R6
      spec_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
         load_zero[l] |-> !consume_fault[l]);
   end
endmodule

bind taint_tag_unit taint_tag_unit_chk #(.NREG(NREG), .LANES(LANES)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .op_valid      (op_valid),
   .op_kind       (op_kind),
   .wr_en         (wr_en),
   .dst           (dst),
   .pred_t        (pred_t),
   .pred_f        (pred_f),
   .redirect_vld  (redirect_vld),
   .load_zero     (load_zero),
   .consume_fault (consume_fault),
   .tag_vec       (tag_vec)
);

// File: tb/taint_tag_unit_tb_top.sv
module taint_tag_unit_tb_top;
   localparam int NREG = 16, LANES = 2, TW = 16, AW = 4;

   logic clk = 1'b0, rst_n = 1'b0, cfg = 1'b0;
   logic [LANES-1:0]    op_valid, wr_en, mem_tag, spec_fault, relax_addr, cmp_raw;
   logic [4*LANES-1:0]  op_kind;
   logic [AW*LANES-1:0] src_a, src_b, dst;
   logic [TW*LANES-1:0] rec_target;
   logic [LANES-1:0]    store_tag, load_zero, pred_t, pred_f, redirect_vld, consume_fault, sec_viol;
   logic [TW*LANES-1:0] redirect_pc;
   logic [NREG-1:0]     tag_vec;

   logic [NREG-1:0] m = '0;
   int checks = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   taint_tag_unit #(.NREG(NREG), .LANES(LANES), .TW(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_load_addr_or(cfg), .op_valid(op_valid),
      .op_kind(op_kind), .wr_en(wr_en), .src_a(src_a), .src_b(src_b), .dst(dst),
      .mem_tag(mem_tag), .spec_fault(spec_fault), .relax_addr(relax_addr),
      .cmp_raw(cmp_raw), .rec_target(rec_target), .store_tag(store_tag),
      .load_zero(load_zero), .pred_t(pred_t), .pred_f(pred_f),
      .redirect_vld(redirect_vld), .redirect_pc(redirect_pc),
      .consume_fault(consume_fault), .sec_viol(sec_viol), .tag_vec(tag_vec));

   task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_lanes();
      op_valid = '0; op_kind = '0; wr_en = '0; src_a = '0; src_b = '0; dst = '0;
      mem_tag = '0; spec_fault = '0; relax_addr = '0; cmp_raw = '0;
   endtask

   task automatic drive(int l, logic [3:0] k, int a, int b, int d, logic we,
                        logic mt, logic sf, logic rl, logic cr);
      op_valid[l] = 1'b1; op_kind[4*l +: 4] = k; wr_en[l] = we;
      src_a[AW*l +: AW] = AW'(a); src_b[AW*l +: AW] = AW'(b); dst[AW*l +: AW] = AW'(d);
      mem_tag[l] = mt; spec_fault[l] = sf; relax_addr[l] = rl; cmp_raw[l] = cr;
   endtask

   task automatic fin();
      @(negedge clk);
      clear_lanes();
   endtask

   task automatic put_tag(int r, logic v);
      drive(0, v ? 4'd9 : 4'd10, 0, 0, r, 1'b1, 0, 0, 0, 0);
      fin();
      if (r != 0) m[r] = v;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      clear_lanes();
      rec_target = {16'h3C5A, 16'hA5C3};
      repeat (3) @(negedge clk);
      cmp("R1 tags in reset", tag_vec, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R1 tags after reset", tag_vec, 0);

      // R2 compute OR sweep, R11 r0 source
      for (int ta = 0; ta < 2; ta++)
         for (int tb = 0; tb < 2; tb++) begin
            put_tag(3, ta[0]); put_tag(5, tb[0]); put_tag(7, ~(ta[0] | tb[0]));
            drive(0, 4'd1, 3, 5, 7, 1, 0, 0, 0, 0); fin();
            m[7] = ta[0] | tb[0];
            cmp("R2 compute OR", tag_vec, m);
            put_tag(7, ~ta[0]);
            drive(0, 4'd1, 3, 3, 7, 1, 0, 0, 0, 0); fin();
            m[7] = ta[0];
            cmp("R2 compute same source", tag_vec, m);
         end

      // R3 self XOR/SUB
      for (int ta = 0; ta < 2; ta++)
         for (int tb = 0; tb < 2; tb++) begin
            put_tag(3, ta[0]); put_tag(5, tb[0]); put_tag(7, 1);
            drive(0, 4'd2, 3, 3, 7, 1, 0, 0, 0, 0); fin();
            m[7] = 0;
            cmp("R3 self cancel", tag_vec, m);
            put_tag(7, ~(ta[0] | tb[0]));
            drive(0, 4'd2, 3, 5, 7, 1, 0, 0, 0, 0); fin();
            m[7] = ta[0] | tb[0];
            cmp("R3 distinct regs", tag_vec, m);
            drive(0, 4'd2, 5, 5, 5, 1, 0, 0, 0, 0); fin();
            m[5] = 0;
            cmp("R3 in place", tag_vec, m);
         end

      // R4 R5 load sweep
      for (int v = 0; v < 16; v++) begin
         logic ta, mt, cf, rl, val, flt;
         {ta, mt, cf, rl} = v[3:0];
         val = mt | (cf & ta);
         flt = ta & ~rl;
         cfg = cf;
         put_tag(2, ta); put_tag(9, ~val);
         drive(0, 4'd3, 2, 0, 9, 1, mt, 0, rl, 0);
         #2 cmp("R5 load consume fault", consume_fault, {1'b0, flt});
         fin();
         if (!flt) m[9] = val;
         cmp("R4 load tag", tag_vec, m);
      end

      // R6 speculative load sweep
      for (int v = 0; v < 32; v++) begin
         logic ta, mt, cf, rl, sf, val;
         {ta, mt, cf, rl, sf} = v[4:0];
         val = sf | mt | (ta & (~rl | cf));
         cfg = cf;
         put_tag(2, ta); put_tag(9, ~val);
         drive(0, 4'd4, 2, 0, 9, 1, mt, sf, rl, 0);
         #2 cmp("R6 spec no fault", consume_fault, 0);
         cmp("R6 load_zero", load_zero, {1'b0, sf});
         fin();
         m[9] = val;
         cmp("R6 spec tag", tag_vec, m);
      end
      cfg = 1'b0;

      // R5 store
      for (int v = 0; v < 8; v++) begin
         logic ta, tb, rl;
         {ta, tb, rl} = v[2:0];
         put_tag(2, ta); put_tag(4, tb);
         drive(0, 4'd5, 2, 4, 4, 1, 0, 0, rl, 0);
         #2 cmp("R5 store_tag", store_tag, {1'b0, tb});
         cmp("R5 store fault", consume_fault, {1'b0, ta & ~rl});
         fin();
         cmp("R5 store no write", tag_vec, m);
      end

      // R7 check, R9 move to special
      for (int ta = 0; ta < 2; ta++) begin
         put_tag(6, ta[0]);
         drive(1, 4'd6, 6, 0, 0, 0, 0, 0, 0, 0);
         drive(0, 4'd11, 6, 0, 0, 0, 0, 0, 0, 0);
         #2 cmp("R7 redirect", redirect_vld, {ta[0], 1'b0});
         cmp("R7 redirect pc", redirect_pc[TW +: TW], 16'h3C5A);
         cmp("R9 sec_viol", sec_viol, {1'b0, ta[0]});
         fin();
      end

      // R8 compares
      for (int v = 0; v < 8; v++) begin
         logic ta, tb, cr, clean;
         {ta, tb, cr} = v[2:0];
         clean = ~(ta | tb);
         put_tag(3, ta); put_tag(5, tb);
         drive(0, 4'd7, 3, 5, 0, 0, 0, 0, 0, cr);
         drive(1, 4'd8, 3, 5, 0, 0, 0, 0, 0, cr);
         #2 cmp("R8 pred_t", pred_t, {cr, clean & cr});
         cmp("R8 pred_f", pred_f, {~cr, clean & ~cr});
         fin();
      end

      // R10 set/clr and wr_en gating
      put_tag(8, 0);
      drive(0, 4'd9, 0, 0, 8, 0, 0, 0, 0, 0); fin();
      cmp("R10 set without wr_en", tag_vec, m);
      drive(0, 4'd1, 3, 5, 8, 0, 0, 0, 0, 0); fin();
      cmp("R10 compute without wr_en", tag_vec, m);
      put_tag(8, 1);
      cmp("R10 set tag", tag_vec, m);
      put_tag(8, 0);
      cmp("R10 clear tag", tag_vec, m);

      // R11 register zero
      put_tag(0, 1);
      cmp("R11 r0 set dropped", tag_vec, m);
      put_tag(7, 1);
      drive(0, 4'd1, 0, 0, 7, 1, 0, 0, 0, 0); fin();
      m[7] = 0;
      cmp("R11 r0 reads clean", tag_vec, m);

      // R12 lane order
      for (int o = 0; o < 2; o++) begin
         drive(0, o ? 4'd10 : 4'd9, 0, 0, 6, 1, 0, 0, 0, 0);
         drive(1, o ? 4'd9 : 4'd10, 0, 0, 6, 1, 0, 0, 0, 0);
         fin();
         m[6] = o[0];
         cmp("R12 later lane wins", tag_vec, m);
      end

      // R13 start-of-cycle reads and idle
      put_tag(4, 0); put_tag(6, 1);
      drive(0, 4'd9, 0, 0, 4, 1, 0, 0, 0, 0);
      drive(1, 4'd1, 4, 4, 6, 1, 0, 0, 0, 0);
      fin();
      m[4] = 1; m[6] = 0;
      cmp("R13 old tag read", tag_vec, m);
      drive(0, 4'd9, 0, 0, 5, 1, 0, 0, 0, 0);
      op_valid = '0;
      fin();
      cmp("R13 idle no change", tag_vec, m);

      summary();
   end
endmodule